// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets boot firmware read numbered configuration items from a small on-chip store. Firmware writes a 16-bit key to pick an item. It then reads the data register repeatedly, and each read returns the next bytes of that item in order. Keys that fall outside the configured range leave the port on an invalid selection. From then on every read returns zero until a valid key is written again. Writes to the data path are accepted on the bus but change nothing.

There are two bus variants, and a parameter picks one. In the split variant the key register and the data register sit at two addresses. The data register takes reads of 1, 2, 4 or 8 bytes, up to a configured maximum width. In the combined variant there is a single address. On that address a 1-byte access reaches the data path and a 2-byte write loads the key.

Each access takes one bus cycle. Read data is valid in the same cycle as the request. The key register and the read offset update at the clock edge that ends the access.

Top module: `cfgkey_port`

## Requirements
- R1: Key bit 15 selects the architecture-local bank (1) or the generic bank (0). Bits 13:0 form the item index. Bit 14 has no effect on which item is selected.
- R2: A key whose index is at or above FIRST_FILE + FILE_SLOTS (40 by default) makes the selection invalid. Every data read then returns all zeros until the next valid key.
- R3: Accepting a key resets the read offset, so the next read starts at byte 0 of the item.
- R4: A data read of N bytes returns the item's next N bytes in the low N bytes of `bus_rdata`. The earliest byte is the most significant one. The offset then advances by N.
- R5: When a read runs past the item's end, the missing low-order bytes read as zero. The offset stops at the item length, so any further read returns zero.
- R6: Writes that reach the data path are accepted with `bus_err` low and leave the key and the offset unchanged.
- R7: Split variant only. At address 0, a 2-byte write loads the key. A read of address 0 returns zero with no error. A write of any other size to address 0 raises `bus_err`, as does a data read wider than DATA_BYTES. A rejected access changes no state. The size code in `bus_size` is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes.
- R8: Combined variant only. Any 1-byte access goes to the data path and a 2-byte write loads the key. Every other access raises `bus_err` and changes no state.
- R9: After reset, key 0 is selected at offset 0.
- R10: Generic item 0 is 4 bytes long and holds SIG_WORD, most significant byte first. Generic item 1 is 4 bytes long. Its first byte is 1 plus 2 when DMA_PRESENT is set, and its other three bytes are zero.
- R11: Every other valid item (bank b, index k) is (3k + 5b) mod (MAX_LEN+1) bytes long. Its byte at offset o is (16k + 7o + 85b) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Split variant: 0 = key register, 1 = data register; unused in the combined variant |
| bus_size | input | 2 | Access size code: 0/1/2/3 = 1/2/4/8 bytes |
| bus_wdata | input | 16 | Write data; key writes use all 16 bits |
| bus_rdata | output | 8*DATA_BYTES | Read data, right-aligned, valid in the request cycle |
| bus_err | output | 1 | Access rejected |

## Verification
The assertions assume that `bus_en` is low or well defined in every cycle after reset. They also assume that `bus_size`, `bus_wr` and `bus_addr` are stable for the whole cycle in which `bus_en` is high. The bench meets both assumptions by changing its inputs only on the falling edge. It lowers `bus_en` after each access. Out-of-range keys and rejected sizes are sent on purpose. The assertions treat them as legal traffic whose state effect is checked, not as protocol violations.

// File: rtl/cfgkey_pkg.sv
`timescale 1ns/1ps
package cfgkey_pkg;
   localparam int KEY_W    = 16;
   localparam int BANK_BIT = 15;
   localparam int IDX_W    = 14;

   typedef logic [IDX_W-1:0] idx_t;

   // bytes in an access for size code s
   function automatic int size_bytes(logic [1:0] s);
      return 1 << s;
   endfunction

   function automatic int item_len(logic bank, idx_t idx, int max_len);
      if (!bank && idx < 2) return 4;
      return (int'(idx) * 3 + (bank ? 5 : 0)) % (max_len + 1);
   endfunction

   function automatic logic [7:0] item_byte(logic bank, idx_t idx, int off,
                                            logic [31:0] sig, logic dma);
      if (!bank && idx == 0) return 8'(sig >> (24 - 8 * (off % 4)));
      if (!bank && idx == 1) return (off == 0) ? {6'b0, dma, 1'b1} : 8'h00;
      return 8'(int'(idx) * 16 + off * 7 + (bank ? 85 : 0));
   endfunction
endpackage

// File: rtl/cfgkey_decode.sv
`timescale 1ns/1ps
module cfgkey_decode #(
   parameter int DATA_BYTES = 4,
   parameter bit COMBINED   = 1'b0
) (
   input  logic       en,
   input  logic       wr,
   input  logic       addr,
   input  logic [1:0] size,
   output logic       sel_hit,
   output logic       rd_hit,
   output logic       reject
);
   localparam logic [1:0] MAX_SZ = 2'($clog2(DATA_BYTES));

   generate
      if (COMBINED) begin : g_comb
         logic unused_addr;
         assign unused_addr = addr;
         always_comb begin
            sel_hit = en && wr && size == 2'd1;
            rd_hit  = en && !wr && size == 2'd0;
            reject  = en && !(size == 2'd0 || (wr && size == 2'd1));
         end
      end else begin : g_split
         always_comb begin
            sel_hit = 1'b0;
            rd_hit  = 1'b0;
            reject  = 1'b0;
            if (en) begin
               if (!addr) begin
                  if (wr) begin
                     if (size == 2'd1) sel_hit = 1'b1;
                     else              reject  = 1'b1;
                  end
               end else if (size > MAX_SZ) begin
                  reject = 1'b1;
               end else if (!wr) begin
                  rd_hit = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfgkey_pack.sv
`timescale 1ns/1ps
module cfgkey_pack
   import cfgkey_pkg::*;
#(
   parameter int          DATA_BYTES  = 4,
   parameter int          MAX_LEN     = 12,
   parameter int          OFF_W       = 4,
   parameter logic [31:0] SIG_WORD    = 32'h4B434647,
   parameter bit          DMA_PRESENT = 1'b1
) (
   input  logic                    valid,
   input  logic                    bank,
   input  idx_t                    idx,
   input  logic [OFF_W-1:0]        off,
   input  logic [1:0]              size,
   output logic [DATA_BYTES*8-1:0] data,
   output logic [OFF_W-1:0]        len,
   output logic [OFF_W-1:0]        next_off
);
   localparam int DW = DATA_BYTES * 8;

   int         len_i;
   int         nb;
   logic [7:0] lane_byte [DATA_BYTES];

   assign nb    = size_bytes(size);
   assign len_i = valid ? item_len(bank, idx, MAX_LEN) : 0;
   assign len   = OFF_W'(len_i);

   generate
      for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
         assign lane_byte[j] = (j < nb && int'(off) + j < len_i) ?
                               item_byte(bank, idx, int'(off) + j, SIG_WORD, DMA_PRESENT) :
                               8'h00;
      end
   endgenerate

   always_comb begin
      data = '0;
      for (int j = 0; j < DATA_BYTES; j++) begin
         if (j < nb) data = data | (DW'(lane_byte[j]) << (8 * (nb - 1 - j)));
      end
   end

   always_comb begin
      if (int'(off) + nb > len_i) next_off = len;
      else                        next_off = OFF_W'(int'(off) + nb);
   end
endmodule

// File: rtl/cfgkey_port.sv
`timescale 1ns/1ps
module cfgkey_port
   import cfgkey_pkg::*;
#(
   parameter int          DATA_BYTES  = 4,
   parameter bit          COMBINED    = 1'b0,
   parameter int          FIRST_FILE  = 32,
   parameter int          FILE_SLOTS  = 8,
   parameter int          MAX_LEN     = 12,
   parameter logic [31:0] SIG_WORD    = 32'h4B434647,
   parameter bit          DMA_PRESENT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_en,
   input  logic                    bus_wr,
   input  logic                    bus_addr,
   input  logic [1:0]              bus_size,
   input  logic [15:0]             bus_wdata,
   output logic [DATA_BYTES*8-1:0] bus_rdata,
   output logic                    bus_err
);
   localparam int LIMIT = FIRST_FILE + FILE_SLOTS;
   localparam int OFF_W = $clog2(MAX_LEN + 1);

   generate
      if (!(DATA_BYTES == 1 || DATA_BYTES == 2 || DATA_BYTES == 4 || DATA_BYTES == 8)) begin : g_bad_width
         $error("DATA_BYTES must be 1, 2, 4 or 8");
      end
      if (LIMIT > (1 << IDX_W)) begin : g_bad_slots
         $error("FIRST_FILE + FILE_SLOTS exceeds the index range");
      end
      if (MAX_LEN < 4) begin : g_bad_len
         $error("MAX_LEN must hold the 4-byte fixed items");
      end
   endgenerate

   logic             cur_valid;
   logic             cur_bank;
   idx_t             cur_idx;
   logic [OFF_W-1:0] cur_off;
   logic [OFF_W-1:0] cur_len;
   logic [OFF_W-1:0] next_off;
   logic [DATA_BYTES*8-1:0] packed_data;
   logic             sel_hit, rd_hit, reject;
   logic             unused_bit14;

   assign unused_bit14 = bus_wdata[14];

   cfgkey_decode #(.DATA_BYTES(DATA_BYTES), .COMBINED(COMBINED)) u_dec (
      .en(bus_en), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
      .sel_hit(sel_hit), .rd_hit(rd_hit), .reject(reject)
   );

   cfgkey_pack #(
      .DATA_BYTES(DATA_BYTES), .MAX_LEN(MAX_LEN), .OFF_W(OFF_W),
      .SIG_WORD(SIG_WORD), .DMA_PRESENT(DMA_PRESENT)
   ) u_pack (
      .valid(cur_valid), .bank(cur_bank), .idx(cur_idx), .off(cur_off),
      .size(bus_size), .data(packed_data), .len(cur_len), .next_off(next_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_valid <= 1'b1;
         cur_bank  <= 1'b0;
         cur_idx   <= '0;
         cur_off   <= '0;
      end else if (sel_hit) begin
         cur_valid <= int'(bus_wdata[IDX_W-1:0]) < LIMIT;
         cur_bank  <= bus_wdata[BANK_BIT];
         cur_idx   <= bus_wdata[IDX_W-1:0];
         cur_off   <= '0;
      end else if (rd_hit && cur_valid) begin
         cur_off   <= next_off;
      end
   end

   assign bus_rdata = rd_hit ? packed_data : '0;
   assign bus_err   = reject;
endmodule

// File: rtl/cfgkey_port_chk.sv
`timescale 1ns/1ps
module cfgkey_port_chk #(
   parameter int DW    = 32,
   parameter int OFF_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_en,
   input logic             bus_wr,
   input logic             bus_err,
   input logic [DW-1:0]    bus_rdata,
   input logic             sel_hit,
   input logic             cur_valid,
   input logic [13:0]      cur_idx,
   input logic [OFF_W-1:0] cur_off,
   input logic [OFF_W-1:0] cur_len
);
   // R2
   invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_valid |-> bus_rdata == '0);

   // R5
   off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_valid |-> cur_off <= cur_len);

   // R3
   sel_clears_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hit |=> cur_off == '0);

   // R7
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> $stable(cur_off) && $stable(cur_idx) && $stable(cur_valid));

   // R6
   data_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && !sel_hit && !bus_err) |=>
         $stable(cur_off) && $stable(cur_idx) && $stable(cur_valid));
endmodule

bind cfgkey_port cfgkey_port_chk #(.DW(DATA_BYTES * 8), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
   .bus_err(bus_err), .bus_rdata(bus_rdata), .sel_hit(sel_hit),
   .cur_valid(cur_valid), .cur_idx(cur_idx), .cur_off(cur_off),
   .cur_len(cur_len)
);

// File: tb/cfgkey_port_test.sv
`timescale 1ns/1ps
module cfgkey_port_test;
   localparam int          DB     = 4;
   localparam int          LIMIT  = 40;
   localparam int          MAXL   = 12;
   localparam logic [31:0] SIG    = 32'h4B434647;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_s = 1'b0, en_c = 1'b0, wr = 1'b0, addr = 1'b0;
   logic [1:0]  sz = 2'd0;
   logic [15:0] wd = 16'h0;
   logic [DB*8-1:0] rd_s;
   logic [7:0]  rd_c;
   logic        err_s, err_c;

   always #5 clk = ~clk;

   cfgkey_port #(.DATA_BYTES(DB), .COMBINED(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_en(en_s), .bus_wr(wr), .bus_addr(addr),
      .bus_size(sz), .bus_wdata(wd), .bus_rdata(rd_s), .bus_err(err_s));

   cfgkey_port #(.DATA_BYTES(1), .COMBINED(1'b1)) uut_comb (
      .clk(clk), .rst_n(rst_n), .bus_en(en_c), .bus_wr(wr), .bus_addr(addr),
      .bus_size(sz), .bus_wdata(wd), .bus_rdata(rd_c), .bus_err(err_c));

   int n_run = 0, n_fail = 0;
   bit m_val, m_bank;
   int m_idx, m_off;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int m_len(bit b, int k);
      if (!m_val) return 0;
      if (!b && k < 2) return 4;
      return (3 * k + 5 * b) % (MAXL + 1);
   endfunction

   function automatic logic [7:0] m_byte(bit b, int k, int o);
      if (!b && k == 0) return SIG[31 - 8 * o -: 8];
      if (!b && k == 1) return (o == 0) ? 8'h03 : 8'h00;
      return 8'((16 * k + 7 * o + 85 * b) % 256);
   endfunction

   task automatic op(input bit comb, input bit w, input bit a, input logic [1:0] s,
                     input logic [15:0] d, output logic [63:0] r, output bit e);
      @(negedge clk);
      wr = w; addr = a; sz = s; wd = d;
      if (comb) en_c = 1'b1; else en_s = 1'b1;
      #1;
      r = comb ? 64'(rd_c) : 64'(rd_s);
      e = comb ? err_c : err_s;
      @(posedge clk);
      #1;
      en_s = 1'b0; en_c = 1'b0;
   endtask

   task automatic sel(input bit comb, input logic [15:0] key);
      logic [63:0] r; bit e;
      op(comb, 1'b1, 1'b0, 2'd1, key, r, e);
      chk("R7 key write error flag", 64'(e), 64'd0);
      m_val  = int'(key[13:0]) < LIMIT;
      m_bank = key[15];
      m_idx  = int'(key[13:0]);
      m_off  = 0;
   endtask

   task automatic exp_read(input int n, output logic [63:0] v);
      int len;
      len = m_len(m_bank, m_idx);
      v = 0;
      for (int j = 0; j < n; j++) begin
         if (m_val && m_off < len) begin
            v = (v << 8) | 64'(m_byte(m_bank, m_idx, m_off));
            m_off++;
         end else begin
            v = v << 8;
         end
      end
   endtask

   task automatic rd(input bit comb, input logic [1:0] s, input string req);
      logic [63:0] r, x; bit e;
      exp_read(1 << s, x);
      op(comb, 1'b0, 1'b1, s, 16'h0, r, e);
      chk(req, r, x);
      chk(req, 64'(e), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] r; bit e;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 / R10: reset state reads the signature
      m_val = 1; m_bank = 0; m_idx = 0; m_off = 0;
      rd(1'b0, 2'd2, "R9 R10 signature after reset");
      rd(1'b0, 2'd0, "R5 read at end of signature");
      m_off = 0;
      rd(1'b1, 2'd0, "R9 R8 combined first signature byte");
      m_off = 0;

      // R10: version item
      sel(1'b0, 16'h0001);
      rd(1'b0, 2'd2, "R10 version item");

      // R7: key register read returns zero, bad sizes rejected
      sel(1'b0, 16'h0002);
      rd(1'b0, 2'd0, "R4 first byte item 2");
      op(1'b0, 1'b0, 1'b0, 2'd2, 16'h0, r, e);
      chk("R7 key register read data", r, 64'd0);
      chk("R7 key register read error", 64'(e), 64'd0);
      op(1'b0, 1'b1, 1'b0, 2'd2, 16'h0005, r, e);
      chk("R7 wide key write rejected", 64'(e), 64'd1);
      rd(1'b0, 2'd0, "R7 state kept after rejected key write");
      op(1'b0, 1'b0, 1'b1, 2'd3, 16'h0, r, e);
      chk("R7 oversize data read rejected", 64'(e), 64'd1);
      rd(1'b0, 2'd0, "R7 state kept after oversize read");

      // R6: data writes ignored
      op(1'b0, 1'b1, 1'b1, 2'd1, 16'hFFFF, r, e);
      chk("R6 data write error flag", 64'(e), 64'd0);
      rd(1'b0, 2'd1, "R6 offset kept after data write");

      // Sweep: R1 R2 R3 R4 R5 R11 over both banks, all indices, all sizes
      for (int b = 0; b < 2; b++)
         for (int k = 0; k < LIMIT + 2; k++)
            for (int al = 0; al < 2; al++)
               for (int s = 0; s < 3; s++) begin
                  int nreads;
                  sel(1'b0, 16'(b << 15) | 16'(al << 14) | 16'(k));
                  nreads = (m_len(m_bank, m_idx) + (1 << s) - 1) / (1 << s) + 1;
                  for (int q = 0; q < nreads; q++)
                     rd(1'b0, 2'(s), m_val ? "R1 R3 R4 R5 R11 sweep read" : "R2 invalid key read");
               end

      // R2: invalid then valid again
      sel(1'b0, 16'd40);
      rd(1'b0, 2'd2, "R2 index at limit reads zero");
      sel(1'b0, 16'h8003);
      rd(1'b0, 2'd2, "R3 valid key after invalid");

      // R8: combined variant
      sel(1'b1, 16'h8004);
      rd(1'b1, 2'd0, "R8 combined byte 0");
      op(1'b1, 1'b1, 1'b0, 2'd0, 16'h00AA, r, e);
      chk("R8 R6 combined byte write accepted", 64'(e), 64'd0);
      rd(1'b1, 2'd0, "R8 R6 combined byte 1 after write");
      op(1'b1, 1'b0, 1'b0, 2'd1, 16'h0, r, e);
      chk("R8 combined 2-byte read rejected", 64'(e), 64'd1);
      op(1'b1, 1'b1, 1'b0, 2'd2, 16'h0001, r, e);
      chk("R8 combined 4-byte write rejected", 64'(e), 64'd1);
      for (int q = 0; q < 12; q++) rd(1'b1, 2'd0, "R8 R5 combined stream");
      sel(1'b1, 16'h4001);
      rd(1'b1, 2'd0, "R1 R10 combined bit 14 ignored");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule